// File: doc/BRIEF.md
# DRAM Controller Configuration Register Bank with Key Lock

This block is the configuration space of a DRAM controller, presented as an array of 32-bit words on a simple register bus. The bus supplies a word index, a write enable with write data, and a read enable. Read data returns one cycle later, together with a valid strobe. Word 0 is a lock word that guards the array. Writing the single unlock key to it opens the bank. Writing any other value to it closes the bank. While the bank is closed, writes to every other word are discarded. Reads are never blocked by the lock.

The configuration word combines bits written by software with fields the hardware fixes. Those fixed fields are a hardware version, an aperture code, an init-done flag and a two-bit DRAM size code derived from the static size parameter. A status word and a self-test word each have bits that are forced to fixed values on every write. This lets boot software that polls them always see an idle, locked, passing controller. The PHY, the ECC engine and the cache are not modelled; only their register faces are.

The bus carries byte address bits [11:2] as the word index, so the 4 KiB window holds 1024 word slots. Only the first DEPTH slots are backed by storage.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write to word 0 of exactly 0xFC600309 makes word 0 read back 1 (open). A write of any other value to word 0 makes it read back 0 (closed).
- R2: While word 0 reads 0, a write to any other word leaves that word's contents unchanged.
- R3: Every read is served whether the bank is open or closed. `rd_valid` is high exactly one cycle after `rd_en`, and `rd_data` is valid in that cycle. A read and a write to the same word in the same cycle return the value held before the write.
- R4: A word index at or above DEPTH reads as 0, and a write to it changes no stored word and not the lock state.
- R5: A write to the configuration word (index 1) clears the read-only bits 31:28, 19, 18:14, 6 and 3:2 from the data, then ORs in the fixed fields: version in 31:28, bit 19 set, aperture code 3 in 3:2, and the size code in 1:0.
- R6: Reset clears word 0 and every storage word to 0, except the configuration word, which takes its fixed fields with all software bits 0 (0x1008000E for the default parameters).
- R7: A write to the status word (index 24) stores the data with bit 0 cleared and, when PLL_LOCK_SET is 1, with bit 4 set.
- R8: A write to the self-test word (index 28) stores the data with bit 12 set and bit 13 cleared.
- R9: A write to any other word inside the array stores the data unchanged, up to the last index DEPTH-1.
- R10: The size code is 0, 1, 2 or 3 for RAM_MIB of 128, 256, 512 or 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 10 | Word index (byte address bits 11:2), shared by read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |

## Verification
Because the bus shares a single index, a read and a write can land on the same word in the same cycle. The bench provokes this by raising both strobes together on a word whose previous contents it knows. It then judges the returned data against the old value, and follows with a plain read that must show the new value. A second overlap is a write to the lock word that closes the bank, followed at once by a data write. The bench judges that the dropped write leaves the word unchanged.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int WIN_W = 10;                      // 4 KiB window / 4-byte words

    localparam logic [31:0] UNLOCK_KEY  = 32'hFC60_0309;
    localparam int          LOCK_IDX    = 0;
    localparam int          CFG_IDX     = 1;
    localparam int          STAT_IDX    = 24;
    localparam int          TEST_IDX    = 28;

    // read-only bits of the configuration word: 31:28, 19, 18:14, 6, 3:2
    localparam logic [31:0] CFG_RO_MASK = 32'hF00F_C04C;
    localparam int          STAT_BUSY_BIT = 0;
    localparam int          STAT_PLL_BIT  = 4;
    localparam int          TEST_DONE_BIT = 12;
    localparam int          TEST_FAIL_BIT = 13;

    typedef struct packed {
        logic             en;
        logic [WIN_W-1:0] idx;
        logic [31:0]      data;
    } reg_wr_t;

    function automatic logic [1:0] size_code(input int mib);
        case (mib)
            128:     return 2'd0;
            256:     return 2'd1;
            512:     return 2'd2;
            1024:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [31:0] cfg_fixed(input int ver, input int mib);
        logic [3:0] v;
        v = 4'(ver);
        return {v, 28'h0} | 32'h0008_000C | {30'h0, size_code(mib)};
    endfunction

endpackage

// File: rtl/cfgb_lock.sv
module cfgb_lock
    import cfgbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output logic        unlocked
);

    always_ff @(posedge clk) begin
        if (rst)         unlocked <= 1'b0;
        else if (key_wr) unlocked <= (key_data == UNLOCK_KEY);
    end

    // R1: the lock word follows the key comparison of the last write to it
    a_r1_key_match: assert property (@(posedge clk) disable iff (rst)
        key_wr |=> (unlocked == ($past(key_data) == UNLOCK_KEY)));

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !key_wr |=> $stable(unlocked));

endmodule

// File: rtl/cfgb_merge.sv
module cfgb_merge
    import cfgbank_pkg::*;
#(
    parameter int HW_VER       = 1,
    parameter int RAM_MIB      = 512,
    parameter bit PLL_LOCK_SET = 1'b1
) (
    input  logic [WIN_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      mdata
);

    localparam logic [31:0] FIXED = cfg_fixed(HW_VER, RAM_MIB);

    always_comb begin
        mdata = wdata;
        case (idx)
            WIN_W'(CFG_IDX): mdata = (wdata & ~CFG_RO_MASK) | FIXED;
            WIN_W'(STAT_IDX): begin
                mdata[STAT_BUSY_BIT] = 1'b0;
                if (PLL_LOCK_SET) mdata[STAT_PLL_BIT] = 1'b1;
            end
            WIN_W'(TEST_IDX): begin
                mdata[TEST_DONE_BIT] = 1'b1;
                mdata[TEST_FAIL_BIT] = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfgb_store.sv
module cfgb_store
    import cfgbank_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter logic [31:0] CFG_RST = 32'h0,
    localparam int         IDX_W   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_in_range,
    input  logic             rd_is_lock,
    input  logic             lock_bit,
    output logic [31:0]      rd_data,
    output logic             rd_valid
);

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i == CFG_IDX) ? CFG_RST : 32'h0;
        end else if (commit) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                if (!rd_in_range)    rd_data <= 32'h0;
                else if (rd_is_lock) rd_data <= {31'h0, lock_bit};
                else                 rd_data <= mem[rd_idx];
            end
        end
    end

    // R3: one-cycle read strobe
    a_r3_rd_valid: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    a_r3_rd_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);
    // R4: outside the array reads zero
    a_r4_oob_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_in_range) |=> (rd_data == 32'h0));
    // R5: fixed configuration fields are always present
    a_r5_cfg_fixed: assert property (@(posedge clk) disable iff (rst)
        ((mem[CFG_IDX] & CFG_RO_MASK) == (CFG_RST & CFG_RO_MASK))
        && ((mem[CFG_IDX] & CFG_RST) == CFG_RST));

    generate
        if (DEPTH > STAT_IDX) begin : g_stat_chk
            // R7: busy never reads set
            a_r7_busy_clear: assert property (@(posedge clk) disable iff (rst)
                mem[STAT_IDX][STAT_BUSY_BIT] == 1'b0);
        end
        if (DEPTH > TEST_IDX) begin : g_test_chk
            // R8: self-test word reads done and passing after a write
            a_r8_test_pass: assert property (@(posedge clk) disable iff (rst)
                (commit && wr_idx == IDX_W'(TEST_IDX))
                |=> (mem[TEST_IDX][TEST_FAIL_BIT:TEST_DONE_BIT] == 2'b01));
        end
    endgenerate

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
    import cfgbank_pkg::*;
#(
    parameter int DEPTH        = 64,
    parameter int RAM_MIB      = 512,
    parameter int HW_VER       = 1,
    parameter bit PLL_LOCK_SET = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] reg_idx,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    output logic [31:0]      rd_data,
    output logic             rd_valid
);

    localparam int          IDX_W   = $clog2(DEPTH);
    localparam logic [31:0] CFG_RST = cfg_fixed(HW_VER, RAM_MIB);

    reg_wr_t     req;
    logic        in_range;
    logic        is_lock;
    logic        unlocked;
    logic        commit;
    logic [31:0] merged;

    assign req      = '{en: wr_en, idx: reg_idx, data: wr_data};
    assign in_range = (32'(reg_idx) < DEPTH);
    assign is_lock  = (reg_idx == WIN_W'(LOCK_IDX));
    assign commit   = req.en && in_range && !is_lock && unlocked;

    cfgb_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (req.en && is_lock),
        .key_data (req.data),
        .unlocked (unlocked)
    );

    cfgb_merge #(
        .HW_VER       (HW_VER),
        .RAM_MIB      (RAM_MIB),
        .PLL_LOCK_SET (PLL_LOCK_SET)
    ) u_merge (
        .idx   (req.idx),
        .wdata (req.data),
        .mdata (merged)
    );

    cfgb_store #(
        .DEPTH   (DEPTH),
        .CFG_RST (CFG_RST)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .wr_idx      (req.idx[IDX_W-1:0]),
        .wr_data     (merged),
        .rd_en       (rd_en),
        .rd_idx      (reg_idx[IDX_W-1:0]),
        .rd_in_range (in_range),
        .rd_is_lock  (is_lock),
        .lock_bit    (unlocked),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    // R2: a closed bank commits nothing
    a_r2_locked_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_lock && !unlocked) |-> !commit);
    // R4: out-of-range writes leave the lock untouched
    a_r4_oob_lock: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_range) |=> $stable(unlocked));

endmodule

// File: tb/tb_memctl_cfg_regs.sv
module tb_memctl_cfg_regs;
    import cfgbank_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  reg_idx = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    memctl_cfg_regs dut (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    localparam int NV = 9;
    // write index, write data, read index, expected read value
    localparam logic [9:0]  V_WI [NV] = '{10'd2, 10'd1, 10'd1, 10'd24, 10'd24,
                                          10'd28, 10'd28, 10'd63, 10'd2};
    localparam logic [31:0] V_WD [NV] = '{32'hDEADBEEF, 32'hFFFFFFFF, 32'h0,
                                          32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF,
                                          32'h0, 32'h12345678, 32'hA5A5A5A5};
    localparam logic [31:0] V_EX [NV] = '{32'hDEADBEEF, 32'h1FF83FBF, 32'h1008000E,
                                          32'hFFFFFFFE, 32'h00000010, 32'hFFFFDFFF,
                                          32'h00001000, 32'h12345678, 32'hA5A5A5A5};
    // R9, R5, R5/R10, R7, R7, R8, R8, R9 (last word), R9
    localparam int          V_RQ [NV] = '{9, 5, 5, 7, 7, 8, 8, 9, 9};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: reset state
        rd(10'd0, v);  check("R6 lock word", v, 32'h0);
        rd(10'd1, v);  check("R6/R10 config word", v, 32'h1008000E);
        rd(10'd2, v);  check("R6 plain word", v, 32'h0);
        rd(10'd24, v); check("R6 status word", v, 32'h0);
        rd(10'd28, v); check("R6 test word", v, 32'h0);

        // R2: write while locked
        wr(10'd2, 32'h11111111);
        rd(10'd2, v);  check("R2 locked write dropped", v, 32'h0);
        wr(10'd1, 32'hFFFFFFFF);
        rd(10'd1, v);  check("R2 locked config unchanged", v, 32'h1008000E);

        // R1: unlock
        wr(10'd0, UNLOCK_KEY);
        rd(10'd0, v);  check("R1 key opens", v, 32'h1);

        // vector table
        for (int k = 0; k < NV; k++) begin
            wr(V_WI[k], V_WD[k]);
            rd(V_WI[k], v);
            check($sformatf("R%0d vector %0d", V_RQ[k], k), v, V_EX[k]);
        end

        // R3: rd_valid timing
        @(negedge clk); reg_idx = 10'd2; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R3 rd_valid high", {31'h0, rd_valid}, 32'h1);
        @(negedge clk);
        check("R3 rd_valid low", {31'h0, rd_valid}, 32'h0);

        // R3: same-cycle read and write returns old value
        @(negedge clk); reg_idx = 10'd2; wr_data = 32'h00000077; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        check("R3 read during write old", rd_data, 32'hA5A5A5A5);
        rd(10'd2, v);  check("R3 read after write new", v, 32'h00000077);

        // R4: out of range
        wr(10'd65, 32'hFFFFFFFF);
        rd(10'd65, v); check("R4 oob read zero", v, 32'h0);
        rd(10'd1, v);  check("R4 no alias config", v, 32'h1008000E);
        rd(10'd0, v);  check("R4 lock untouched", v, 32'h1);
        rd(10'd1023, v); check("R4 top of window zero", v, 32'h0);

        // R1: wrong key closes, then R2 drop
        wr(10'd0, 32'hFC600308);
        rd(10'd0, v);  check("R1 wrong key closes", v, 32'h0);
        wr(10'd2, 32'h00000066);
        rd(10'd2, v);  check("R2 drop after relock", v, 32'h00000077);
        rd(10'd28, v); check("R3 read while locked", v, 32'h00001000);

        // R6: reset mid-run
        wr(10'd0, UNLOCK_KEY);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(10'd0, v);  check("R6 lock after reset", v, 32'h0);
        rd(10'd2, v);  check("R6 word after reset", v, 32'h0);
        rd(10'd1, v);  check("R6 config after reset", v, 32'h1008000E);

        finish_run();
    end

endmodule